// File: doc/BRIEF.md
# Multi-rate SONET/SDH frame aligner

The block takes a serial SONET/SDH line, one bit per cycle in which the bit enable is high, and finds where the A1/A2 framing bytes sit. While it is hunting, it slides a shift window over the stream and compares the newest bits against a framing pattern at every bit position. Configuration selects how wide that pattern is. When the pattern is found, the block fixes the byte phase and the position in the frame, and from then on it delivers byte-aligned data, most significant bit first.

Once aligned, the block looks for the pattern only at the place where the next frame should carry it. Missed and found patterns are counted to drive a severely errored frame (SEF) flag. Two configuration bits choose how reframing is done:

- In automatic mode, losing frame sends the block back to hunting.
- In manual mode, a search request bit either lets the block hunt or holds the present alignment.

The line rate sets the frame length, and an invalid rate code stops all searching.

Top module: `frame_aligner`

## Requirements
- R1: After reset, `inFrame` is 0, `sefFlag` is 1, `framePulse` and `byteValid` are 0, and the block is hunting.
- R2: `widthSel` chooses the framing pattern, compared against the newest received bits. 00 selects the 12-bit pattern 0xF62, 10 the 24-bit pattern 0xF6F628, and 01 the 48-bit pattern 0xF6F6F6282828. 11 disables all searching and checking, so the block never acquires frame.
- R3: `rateSel` gives the multiplier N: 00 gives 48, 01 gives 3, 10 gives 12. A frame is FRAME_UNIT*N bytes, with A1 (0xF6) in bytes 0..N-1 and A2 (0x28) in bytes N..2N-1. The code 11 drives `rateBad` high, and with that code the block never acquires frame.
- R4: A match sets the byte phase so that every output byte is a whole byte of the stream, first bit received in bit 7. For a 12-bit match the last matched bit is the fourth bit of byte N; for a 24-bit match it is the last bit of byte N; for a 48-bit match it is the last bit of byte N+2. While `inFrame` is 1, `framePulse` is high for one cycle, together with `byteValid`, when byte 2N (the first byte after the last A2) is delivered on `dataOut`. The next valid byte is byte 2N+1.
- R5: While alignment holds, consecutive frame pulses are exactly FRAME_UNIT*N delivered bytes apart.
- R6: Once in frame, the pattern is checked only at its expected position. Four consecutive misses there set `sefFlag`.
- R7: Two consecutive good checks while in frame clear `sefFlag`. A single good check does not clear it.
- R8: In automatic mode (`manualMode`=0), the block leaves frame and hunts at every bit position in two cases: a missed check that leaves `sefFlag` set, and reaching four misses. It then realigns to the pattern wherever it next appears, including at a new bit phase.
- R9: In manual mode (`manualMode`=1), `searchReq`=1 makes the block hunt at every bit and take each match as the alignment. `searchReq`=0 holds the alignment with no hunting, even when `sefFlag` sets; only the expected-position checks run.
- R10: In automatic mode `searchReq` has no effect. With it held at 1, the block still stops hunting after acquisition, and `sefFlag` clears after two good checks.
- R11: Only cycles with `bitEn`=1 move the block. `byteValid` and `framePulse` only follow a cycle with `bitEn` high, and `inFrame` and `sefFlag` hold through cycles with `bitEn` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Marks a cycle carrying a new line bit |
| serIn | input | 1 | Serial line bit |
| rateSel | input | 2 | Line rate code (00 N=48, 01 N=3, 10 N=12, 11 invalid) |
| widthSel | input | 2 | Framing pattern width code (00 12-bit, 10 24-bit, 01 48-bit, 11 off) |
| manualMode | input | 1 | 0 automatic reframing, 1 manual reframing |
| searchReq | input | 1 | In manual mode: 1 hunt, 0 hold alignment |
| dataOut | output | 8 | Aligned byte, first received bit in bit 7 |
| byteValid | output | 1 | One-cycle strobe for a new `dataOut` byte |
| framePulse | output | 1 | One-cycle strobe on byte 2N of an aligned frame |
| inFrame | output | 1 | Alignment held |
| sefFlag | output | 1 | Severely errored frame condition |
| rateBad | output | 1 | Invalid rate code present |

## Verification
A match for the 24-bit or 48-bit pattern ends exactly on a byte boundary. In that cycle the block loads a new alignment and completes an output byte, so realignment and byte delivery coincide. The bench provokes this by acquiring frame at several rates and widths, and once after a three-bit slip of the stream. It judges the outcome by requiring that every later frame pulse carries the marker byte placed at position 2N, and that the byte after it is the second marker, so a phase error of even one bit shows up as wrong data.

// File: rtl/frame_aligner_pkg.sv
package frame_aligner_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } alignState_t;

  // control -> datapath
  typedef struct packed {
    logic hunt;    // compare at every bit and load alignment on a match
    logic locked;  // alignment valid, frame pulses allowed
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic hit;      // new bit taken and window matches the selected pattern
    logic checkPt;  // new bit taken and it is the expected last pattern bit
  } dpStatus_t;

  localparam logic [11:0] PAT_NARROW = 12'hF62;
  localparam logic [23:0] PAT_MID    = 24'hF6F628;
  localparam logic [47:0] PAT_WIDE   = 48'hF6F6F6282828;

  localparam int WIN_BITS = 48;

  function automatic logic [5:0] rateMult(input logic [1:0] sel);
    case (sel)
      2'b01:   rateMult = 6'd3;
      2'b10:   rateMult = 6'd12;
      default: rateMult = 6'd48;
    endcase
  endfunction

endpackage

// File: rtl/frame_aligner_dp.sv
module frame_aligner_dp
  import frame_aligner_pkg::*;
#(
  parameter int FRAME_UNIT = 810
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitEn,
  input  logic        serIn,
  input  logic [1:0]  rateSel,
  input  logic [1:0]  widthSel,
  input  ctrlStrobe_t ctrl,
  output dpStatus_t   status,
  output logic [7:0]  dataOut,
  output logic        byteValid,
  output logic        framePulse
);

  localparam int MAX_BITS = FRAME_UNIT * 48 * 8;
  localparam int PW = $clog2(MAX_BITS) + 1;

  logic [WIN_BITS-1:0] win, nextWin;
  logic                match;
  logic [PW-1:0]       unitW, nW, frameBits, endBit, pulseBit;
  logic [PW-1:0]       pos, posInc, posNew;
  logic                load;

  assign nextWin = {win[WIN_BITS-2:0], serIn};

  always_comb begin
    case (widthSel)
      2'b00:   match = (nextWin[11:0] == PAT_NARROW);
      2'b10:   match = (nextWin[23:0] == PAT_MID);
      2'b01:   match = (nextWin[47:0] == PAT_WIDE);
      default: match = 1'b0;
    endcase
  end

  assign unitW     = PW'(FRAME_UNIT);
  assign nW        = PW'(rateMult(rateSel));
  assign frameBits = (unitW * nW) << 3;
  assign pulseBit  = ((nW << 1) + PW'(1)) << 3;

  // bit count of the frame consumed once the last pattern bit is in
  always_comb begin
    case (widthSel)
      2'b00:   endBit = (nW << 3) + PW'(4);
      2'b10:   endBit = (nW + PW'(1)) << 3;
      default: endBit = (nW + PW'(3)) << 3;
    endcase
  end

  assign posInc = ((pos + PW'(1)) >= frameBits) ? '0 : pos + PW'(1);
  assign load   = ctrl.hunt && bitEn && match;
  assign posNew = load ? endBit : posInc;

  assign status.hit     = bitEn && match;
  assign status.checkPt = bitEn && (posInc == endBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      win        <= '0;
      pos        <= '0;
      dataOut    <= '0;
      byteValid  <= 1'b0;
      framePulse <= 1'b0;
    end else if (bitEn) begin
      win        <= nextWin;
      pos        <= posNew;
      byteValid  <= (posNew[2:0] == 3'd0);
      framePulse <= (posNew == pulseBit) && ctrl.locked;
      if (posNew[2:0] == 3'd0) dataOut <= nextWin[7:0];
    end else begin
      byteValid  <= 1'b0;
      framePulse <= 1'b0;
    end
  end

endmodule

// File: rtl/frame_aligner_ctrl.sv
module frame_aligner_ctrl
  import frame_aligner_pkg::*;
#(
  parameter int LOSS_LIMIT = 4,
  parameter int GOOD_LIMIT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  input  logic [1:0]  rateSel,
  input  logic [1:0]  widthSel,
  input  logic        manualMode,
  input  logic        searchReq,
  output ctrlStrobe_t ctrl,
  output logic        inFrame,
  output logic        sefFlag,
  output logic        rateBad
);

  localparam int MW = $clog2(LOSS_LIMIT + 1);
  localparam int GW = $clog2(GOOD_LIMIT + 1);

  alignState_t   state;
  logic [MW-1:0] missCnt;
  logic [GW-1:0] okCnt;
  logic          enable, hunt, acquire, checkEv, goodChk, badChk;
  logic          lossHit, sefAfterMiss;

  assign rateBad = (rateSel == 2'b11);
  assign enable  = !rateBad && (widthSel != 2'b11);
  assign hunt    = enable && (manualMode ? searchReq : (state == ST_HUNT));
  assign acquire = hunt && status.hit;
  assign checkEv = enable && !hunt && (state == ST_LOCK) && status.checkPt;
  assign goodChk = checkEv && status.hit;
  assign badChk  = checkEv && !status.hit;

  assign lossHit      = (int'(missCnt) + 1) >= LOSS_LIMIT;
  assign sefAfterMiss = sefFlag || lossHit;

  assign ctrl.hunt   = hunt;
  assign ctrl.locked = (state == ST_LOCK);
  assign inFrame     = (state == ST_LOCK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      sefFlag <= 1'b1;
      missCnt <= '0;
      okCnt   <= '0;
    end else if (acquire) begin
      state   <= ST_LOCK;
      missCnt <= '0;
      okCnt   <= '0;
    end else if (goodChk) begin
      missCnt <= '0;
      if ((int'(okCnt) + 1) >= GOOD_LIMIT) sefFlag <= 1'b0;
      else okCnt <= okCnt + 1'b1;
    end else if (badChk) begin
      okCnt <= '0;
      if (lossHit) sefFlag <= 1'b1;
      else missCnt <= missCnt + 1'b1;
      if (!manualMode && sefAfterMiss) state <= ST_HUNT;
    end
  end

endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
  import frame_aligner_pkg::*;
#(
  parameter int FRAME_UNIT = 810,
  parameter int LOSS_LIMIT = 4,
  parameter int GOOD_LIMIT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       serIn,
  input  logic [1:0] rateSel,
  input  logic [1:0] widthSel,
  input  logic       manualMode,
  input  logic       searchReq,
  output logic [7:0] dataOut,
  output logic       byteValid,
  output logic       framePulse,
  output logic       inFrame,
  output logic       sefFlag,
  output logic       rateBad
);

  ctrlStrobe_t ctrl;
  dpStatus_t   status;

  frame_aligner_dp #(.FRAME_UNIT(FRAME_UNIT)) u_dp (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .serIn(serIn),
    .rateSel(rateSel), .widthSel(widthSel), .ctrl(ctrl), .status(status),
    .dataOut(dataOut), .byteValid(byteValid), .framePulse(framePulse)
  );

  frame_aligner_ctrl #(.LOSS_LIMIT(LOSS_LIMIT), .GOOD_LIMIT(GOOD_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .status(status), .rateSel(rateSel),
    .widthSel(widthSel), .manualMode(manualMode), .searchReq(searchReq),
    .ctrl(ctrl), .inFrame(inFrame), .sefFlag(sefFlag), .rateBad(rateBad)
  );

endmodule

// File: rtl/frame_aligner_chk.sv
module frame_aligner_chk (
  input logic       clk,
  input logic       rstN,
  input logic       bitEn,
  input logic [1:0] rateSel,
  input logic [1:0] widthSel,
  input logic       manualMode,
  input logic       searchReq,
  input logic       byteValid,
  input logic       framePulse,
  input logic       inFrame,
  input logic       sefFlag
);

  a_r4_pulse_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    framePulse |-> (inFrame && byteValid));

  a_r11_byte_after_bit: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(bitEn));

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !$past(bitEn) |-> ($stable(inFrame) && $stable(sefFlag)));

  a_r3_no_lock_invalid: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inFrame) |-> ($past(rateSel) != 2'b11 && $past(widthSel) != 2'b11));

  a_r9_manual_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inFrame) |-> (!$past(manualMode) || $past(searchReq)));

  a_r7_clear_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sefFlag) |-> inFrame);

  a_r6_set_from_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sefFlag) |-> $past(inFrame));

  a_r8_auto_drop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sefFlag) |-> ($past(manualMode) || !inFrame));

endmodule

bind frame_aligner frame_aligner_chk u_chk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .rateSel(rateSel),
  .widthSel(widthSel), .manualMode(manualMode), .searchReq(searchReq),
  .byteValid(byteValid), .framePulse(framePulse), .inFrame(inFrame),
  .sefFlag(sefFlag)
);

// File: tb/sim_frame_aligner.sv
`timescale 1ns/1ps
module sim_frame_aligner;

  localparam int FU = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic       serIn = 1'b0;
  logic [1:0] rateSel = 2'b01;
  logic [1:0] widthSel = 2'b10;
  logic       manualMode = 1'b0;
  logic       searchReq = 1'b0;
  logic [7:0] dataOut;
  logic       byteValid, framePulse, inFrame, sefFlag, rateBad;

  int total = 0;
  int bad = 0;
  int nCur = 3;
  logic [7:0] expMark = 8'h00;
  logic [7:0] expMark2 = 8'h00;
  int pulseCount = 0;
  int byteCount = 0;
  int bytesSince = 0;
  bit havePrev = 0;
  bit wantNext = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  frame_aligner #(.FRAME_UNIT(FU)) u0 (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .serIn(serIn),
    .rateSel(rateSel), .widthSel(widthSel), .manualMode(manualMode),
    .searchReq(searchReq), .dataOut(dataOut), .byteValid(byteValid),
    .framePulse(framePulse), .inFrame(inFrame), .sefFlag(sefFlag),
    .rateBad(rateBad)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fillByte();
    return 8'($urandom) & 8'h33;  // never four ones in a row: no false pattern
  endfunction

  task automatic sendBit(input logic b);
    @(negedge clk);
    bitEn = 1'b1;
    serIn = b;
    @(negedge clk);
    bitEn = 1'b0;
    serIn = 1'($urandom);
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
  endtask

  task automatic sendFrame(input int n, input bit good);
    for (int i = 0; i < n; i++) sendByte(good ? 8'hF6 : 8'h00);
    for (int i = 0; i < n; i++) sendByte(good ? 8'h28 : 8'h00);
    expMark  = fillByte() | 8'h01;
    expMark2 = fillByte();
    sendByte(expMark);
    sendByte(expMark2);
    for (int i = 2 * n + 2; i < FU * n; i++) sendByte(fillByte());
  endtask

  task automatic doReset(input logic [1:0] r, input logic [1:0] w,
                         input logic m, input logic s, input int n);
    @(negedge clk);
    rstN = 1'b0;
    bitEn = 1'b0;
    rateSel = r;
    widthSel = w;
    manualMode = m;
    searchReq = s;
    nCur = n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    pulseCount = 0;
    for (int i = 0; i < 3; i++) sendByte(8'h00);
  endtask

  // byte and frame pulse monitor (R4, R5)
  always @(negedge clk) begin
    if (!rstN) begin
      havePrev = 0;
      wantNext = 0;
    end else begin
      if (byteValid) begin
        byteCount++;
        if (wantNext) begin
          check(dataOut == expMark2, "R4 byte after pulse", dataOut, expMark2);
          wantNext = 0;
        end
        if (framePulse) begin
          pulseCount++;
          check(inFrame == 1'b1, "R4 pulse while in frame", inFrame, 1);
          check(dataOut == expMark, "R4 pulse byte 2N", dataOut, expMark);
          if (havePrev)
            check(bytesSince == FU * nCur, "R5 pulse spacing", bytesSince, FU * nCur);
          havePrev = 1;
          bytesSince = 1;
          wantNext = 1;
        end else begin
          bytesSince++;
        end
      end else begin
        check(framePulse == 1'b0, "R4 pulse without byte", framePulse, 0);
      end
      if (!inFrame) havePrev = 0;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (2) @(negedge clk);
    // R1 reset state
    check(inFrame == 1'b0, "R1 inFrame at reset", inFrame, 0);
    check(sefFlag == 1'b1, "R1 sefFlag at reset", sefFlag, 1);
    check(byteValid == 1'b0 && framePulse == 1'b0, "R1 strobes at reset",
          {byteValid, framePulse}, 0);

    // auto, N=3, 24-bit pattern, searchReq held at 1 (R10)
    doReset(2'b01, 2'b10, 1'b0, 1'b1, 3);
    check(inFrame == 1'b0, "R1 hunting before pattern", inFrame, 0);
    sendFrame(3, 1);
    check(inFrame == 1'b1, "R2 24-bit acquire", inFrame, 1);
    check(sefFlag == 1'b1, "R7 still set before checks", sefFlag, 1);
    sendFrame(3, 1);
    check(sefFlag == 1'b1, "R7 one good check is not enough", sefFlag, 1);
    sendFrame(3, 1);
    check(sefFlag == 1'b0, "R7 cleared after two good (R10 ignored)", sefFlag, 0);
    check(pulseCount == 3, "R5 one pulse per frame", pulseCount, 3);
    for (int k = 0; k < 3; k++) sendFrame(3, 0);
    check(sefFlag == 1'b0, "R6 three misses keep sef low", sefFlag, 0);
    check(inFrame == 1'b1, "R6 three misses keep frame", inFrame, 1);
    sendFrame(3, 0);
    check(sefFlag == 1'b1, "R6 fourth miss sets sef", sefFlag, 1);
    check(inFrame == 1'b0, "R8 auto drops frame", inFrame, 0);
    for (int i = 0; i < 3; i++) sendBit(1'b0);  // bit slip
    sendFrame(3, 1);
    check(inFrame == 1'b1, "R8 relock after slip", inFrame, 1);
    sendFrame(3, 1);
    sendFrame(3, 1);
    check(sefFlag == 1'b0, "R8 sef clears after relock", sefFlag, 0);

    // 12-bit pattern, N=12
    doReset(2'b10, 2'b00, 1'b0, 1'b0, 12);
    sendFrame(12, 1);
    check(inFrame == 1'b1, "R2 12-bit acquire", inFrame, 1);
    sendFrame(12, 1);
    sendFrame(12, 1);
    check(sefFlag == 1'b0, "R3 N=12 checks good", sefFlag, 0);
    check(pulseCount == 3, "R3 N=12 pulses", pulseCount, 3);

    // 48-bit pattern, N=48
    doReset(2'b00, 2'b01, 1'b0, 1'b0, 48);
    sendFrame(48, 1);
    check(inFrame == 1'b1, "R2 48-bit acquire", inFrame, 1);
    sendFrame(48, 1);
    sendFrame(48, 1);
    check(sefFlag == 1'b0, "R3 N=48 checks good", sefFlag, 0);

    // search disabled
    doReset(2'b01, 2'b11, 1'b0, 1'b0, 3);
    sendFrame(3, 1);
    sendFrame(3, 1);
    check(inFrame == 1'b0, "R2 code 11 no acquire", inFrame, 0);
    check(pulseCount == 0, "R2 code 11 no pulses", pulseCount, 0);

    // invalid rate
    doReset(2'b11, 2'b10, 1'b0, 1'b0, 3);
    check(rateBad == 1'b1, "R3 invalid rate flagged", rateBad, 1);
    sendFrame(3, 1);
    sendFrame(3, 1);
    check(inFrame == 1'b0, "R3 invalid rate no acquire", inFrame, 0);

    // manual mode
    doReset(2'b01, 2'b10, 1'b1, 1'b0, 3);
    check(rateBad == 1'b0, "R3 valid rate not flagged", rateBad, 0);
    sendFrame(3, 1);
    sendFrame(3, 1);
    check(inFrame == 1'b0, "R9 hold without request", inFrame, 0);
    searchReq = 1'b1;
    sendFrame(3, 1);
    check(inFrame == 1'b1, "R9 request acquires", inFrame, 1);
    searchReq = 1'b0;
    sendFrame(3, 1);
    sendFrame(3, 1);
    check(sefFlag == 1'b0, "R9 held alignment checks good", sefFlag, 0);
    for (int k = 0; k < 4; k++) sendFrame(3, 0);
    check(sefFlag == 1'b1, "R6 manual four misses", sefFlag, 1);
    check(inFrame == 1'b1, "R9 manual keeps alignment", inFrame, 1);
    pulseCount = 0;
    sendFrame(3, 1);
    sendFrame(3, 1);
    check(sefFlag == 1'b0, "R9 recover on held alignment", sefFlag, 0);
    check(pulseCount == 2, "R9 pulses on held alignment", pulseCount, 2);

    // R11 idle cycles move nothing
    begin
      int bc;
      logic f0, s0;
      bc = byteCount;
      f0 = inFrame;
      s0 = sefFlag;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        bitEn = 1'b0;
        serIn = 1'($urandom);
      end
      check(byteCount == bc, "R11 no bytes without bitEn", byteCount, bc);
      check(inFrame == f0 && sefFlag == s0, "R11 flags hold without bitEn",
            {inFrame, sefFlag}, {f0, s0});
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R11 act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule